// File: doc/BRIEF.md
# USB Device Command Register File

This block sits on the processor side of a full-speed USB peripheral controller. The host processor first issues an 8-bit command code on a command strobe. It then moves one data byte with a write strobe or a read strobe. The block holds sixteen endpoint configuration bytes and a programmed device address byte. Indices 0 and 1 are the control OUT and control IN endpoints, and indices 2 to 15 are endpoints 1 to 14.

The block keeps a second copy of the address, the active address, together with an enable flag. The serial interface engine matches packets against this active copy. A new programmed address only becomes active when the host acknowledges the empty status packet that follows it. A USB bus reset zeroes the active address and enables the device, but the programmed byte keeps its value.

When a configuration write alters the memory allocation of an endpoint, the block pulses an invalidate line. Memory allocation means the enable bit or the size code. The FIFO logic uses this pulse to discard the contents of every endpoint.

Top module: `usb_cmd_regfile`

## Requirements
- R1: After the asynchronous reset all sixteen configuration bytes, the programmed address byte, the active address, the device enable, rd_data and fifo_invalidate are all 0.
- R2: After command 0x20+i, a write strobe stores wr_data into configuration byte i (i = 0..15), which appears on ep_cfg[8*i+7:8*i] on the next cycle; command 0x30+i followed by a read strobe returns that byte.
- R3: After command 0xB6, a write strobe stores wr_data as the programmed address byte (bit 7 enable, bits 6:0 address); command 0xB7 followed by a read strobe returns it.
- R4: active_addr and dev_enable hold their values after an address write and only take bits 6:0 and bit 7 of the programmed byte in the cycle after status_ack is seen with an update pending; status_ack with nothing pending has no effect.
- R5: The cycle after bus_reset, active_addr is 0 and dev_enable is 1; the programmed address byte read by 0xB7 is unchanged.
- R6: A bus_reset that arrives while an address update is pending cancels it, so a later status_ack leaves active_addr and dev_enable unchanged.
- R7: A configuration write that changes bit 7 (FIFO enable) or bits 3:0 (size code) of the addressed byte raises fifo_invalidate for exactly the one cycle after the write strobe.
- R8: A configuration write that changes only bits 6:4 (direction, double buffer, isochronous) or rewrites the same value leaves fifo_invalidate low.
- R9: Write strobes after any other command code change no stored byte, and read strobes after such a code return 0x00.
- R10: rd_data is loaded only on a read strobe and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_stb | input | 1 | Latches cmd_code as the current command |
| cmd_code | input | 8 | Command code |
| wr_stb | input | 1 | Writes wr_data under the current command |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Loads rd_data under the current command |
| rd_data | output | 8 | Read data byte |
| bus_reset | input | 1 | USB bus reset seen by the serial engine |
| status_ack | input | 1 | Host acknowledged the empty IN status packet |
| active_addr | output | 7 | Address used by the serial engine |
| dev_enable | output | 1 | Device enable used by the serial engine |
| fifo_invalidate | output | 1 | One-cycle pulse: discard all FIFO contents |
| ep_cfg | output | 128 | All sixteen configuration bytes, byte i at bits 8i+7:8i |

## Verification
A corrupted configuration byte shows on ep_cfg in the next cycle and on rd_data after the next matching read. A wrong pending flag appears only later, on the cycle after a status_ack, as an active address that moves too early, too late or not at all. For this reason the bench follows every address write with idle cycles, acknowledges, and bus resets in both orders. A wrong invalidate decision shows one cycle after the write strobe, so every configuration write is compared against a model of the enable and size bits.

// File: rtl/usb_cmd_regfile.sv
module usb_cmd_regfile #(
  parameter int         NUM_EP      = 16,
  parameter logic [7:0] EP_WR_BASE  = 8'h20,
  parameter logic [7:0] EP_RD_BASE  = 8'h30,
  parameter logic [7:0] ADR_WR_CODE = 8'hB6,
  parameter logic [7:0] ADR_RD_CODE = 8'hB7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_stb,
  input  logic [7:0]            cmd_code,
  input  logic                  wr_stb,
  input  logic [7:0]            wr_data,
  input  logic                  rd_stb,
  output logic [7:0]            rd_data,
  input  logic                  bus_reset,
  input  logic                  status_ack,
  output logic [6:0]            active_addr,
  output logic                  dev_enable,
  output logic                  fifo_invalidate,
  output logic [NUM_EP*8-1:0]   ep_cfg
);
  localparam int         EPW  = $clog2(NUM_EP);
  localparam logic [7:0] NEP8 = 8'(NUM_EP);

  logic [7:0]     cmd_q;
  logic [7:0]     cfg_q [NUM_EP];
  logic [7:0]     adr_q;
  logic           pend_q;
  logic [7:0]     rd_mux;
  logic [7:0]     wr_off, rd_off;
  logic [EPW-1:0] wr_idx, rd_idx;
  logic           ep_wr_hit, ep_rd_hit, adr_wr, alloc_chg;

  assign wr_off    = cmd_q - EP_WR_BASE;
  assign rd_off    = cmd_q - EP_RD_BASE;
  assign wr_idx    = wr_off[EPW-1:0];
  assign rd_idx    = rd_off[EPW-1:0];
  assign ep_wr_hit = (cmd_q >= EP_WR_BASE) && (wr_off < NEP8);
  assign ep_rd_hit = (cmd_q >= EP_RD_BASE) && (rd_off < NEP8);
  assign adr_wr    = wr_stb && (cmd_q == ADR_WR_CODE);
  assign alloc_chg = wr_stb && ep_wr_hit &&
                     ((wr_data[7] != cfg_q[wr_idx][7]) || (wr_data[3:0] != cfg_q[wr_idx][3:0]));

  always_comb begin
    rd_mux = '0;
    if (ep_rd_hit)                 rd_mux = cfg_q[rd_idx];
    else if (cmd_q == ADR_RD_CODE) rd_mux = adr_q;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cmd_q <= '0;
    else if (cmd_stb) cmd_q <= cmd_code;

  generate
    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                                    cfg_q[g] <= '0;
        else if (wr_stb && ep_wr_hit && wr_idx == g)   cfg_q[g] <= wr_data;
      assign ep_cfg[8*g +: 8] = cfg_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      adr_q           <= '0;
      pend_q          <= 1'b0;
      active_addr     <= '0;
      dev_enable      <= 1'b0;
      rd_data         <= '0;
      fifo_invalidate <= 1'b0;
    end else begin
      fifo_invalidate <= alloc_chg;
      if (rd_stb) rd_data <= rd_mux;
      if (bus_reset) begin
        active_addr <= '0;
        dev_enable  <= 1'b1;
        pend_q      <= 1'b0;
      end else if (status_ack && pend_q) begin
        active_addr <= adr_q[6:0];
        dev_enable  <= adr_q[7];
        pend_q      <= 1'b0;
      end
      if (adr_wr) begin
        adr_q  <= wr_data;
        pend_q <= 1'b1;
      end
    end

  p_active_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_ack && !bus_reset) |=> ($stable(active_addr) && $stable(dev_enable)));

  p_ack_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_ack && pend_q && !bus_reset) |=> (active_addr == $past(adr_q[6:0]) && dev_enable == $past(adr_q[7])));

  p_busrst_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (active_addr == 7'd0 && dev_enable));

  p_busrst_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !adr_wr) |=> $stable(adr_q));

  p_busrst_cancel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !adr_wr) |=> !pend_q);

  p_inv_after_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_invalidate |-> $past(wr_stb));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: tb/test_usb_cmd_regfile.sv
`timescale 1ns/100ps
module test_usb_cmd_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_stb = 0, wr_stb = 0, rd_stb = 0, bus_reset = 0, status_ack = 0;
  logic [7:0] cmd_code = 0, wr_data = 0;
  logic [7:0] rd_data;
  logic [6:0] active_addr;
  logic dev_enable, fifo_invalidate;
  logic [127:0] ep_cfg;

  usb_cmd_regfile i_usb_cmd_regfile (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .bus_reset(bus_reset), .status_ack(status_ack), .active_addr(active_addr),
    .dev_enable(dev_enable), .fifo_invalidate(fifo_invalidate), .ep_cfg(ep_cfg));

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  string req = "R1";

  int m_cmd, m_adr, m_act, m_en, m_pend, m_rd, m_inv;
  int m_cfg [16];

  function automatic int model_read();
    if (m_cmd >= 'h30 && m_cmd <= 'h3F) return m_cfg[m_cmd - 'h30];
    if (m_cmd == 'hB7) return m_adr;
    return 0;
  endfunction

  always @(posedge clk) begin
    int rd_n, inv_n;
    if (!rst_n) begin
      m_cmd = 0; m_adr = 0; m_act = 0; m_en = 0; m_pend = 0; m_rd = 0; m_inv = 0;
      foreach (m_cfg[k]) m_cfg[k] = 0;
    end else begin
      rd_n = rd_stb ? model_read() : m_rd;
      inv_n = 0;
      if (bus_reset) begin m_act = 0; m_en = 1; m_pend = 0; end
      else if (status_ack && m_pend != 0) begin
        m_act = m_adr % 128; m_en = m_adr / 128; m_pend = 0;
      end
      if (wr_stb) begin
        if (m_cmd >= 'h20 && m_cmd <= 'h2F) begin
          int old;
          old = m_cfg[m_cmd - 'h20];
          if ((old / 128) != (int'(wr_data) / 128) || (old % 16) != (int'(wr_data) % 16)) inv_n = 1;
          m_cfg[m_cmd - 'h20] = wr_data;
        end else if (m_cmd == 'hB6) begin
          m_adr = wr_data; m_pend = 1;
        end
      end
      if (cmd_stb) m_cmd = cmd_code;
      m_rd = rd_n; m_inv = inv_n;
    end
  end

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n || cycles > 0) begin
    cycles++;
    cmp("rd_data", rd_data, m_rd);
    cmp("active_addr", active_addr, m_act);
    cmp("dev_enable", dev_enable, m_en);
    cmp("fifo_invalidate", fifo_invalidate, m_inv);
    for (int k = 0; k < 16; k++) cmp($sformatf("ep_cfg[%0d]", k), ep_cfg[8*k +: 8], m_cfg[k]);
  end

  task automatic step(); @(negedge clk); #1; cmd_stb = 0; wr_stb = 0; rd_stb = 0; bus_reset = 0; status_ack = 0; endtask
  task automatic do_cmd(int c); cmd_stb = 1; cmd_code = 8'(c); step(); endtask
  task automatic do_wr(int d); wr_stb = 1; wr_data = 8'(d); step(); endtask
  task automatic do_rd(); rd_stb = 1; step(); endtask
  task automatic do_ack(); status_ack = 1; step(); endtask
  task automatic do_brst(); bus_reset = 1; step(); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) step(); endtask

  initial begin
    int seed;
    @(negedge clk); #1;
    req = "R1"; idle(2);
    rst_n = 1; idle(2);

    req = "R2";
    for (int i = 0; i < 16; i++) begin do_cmd('h20 + i); do_wr((i * 37 + 11) % 256); end
    for (int i = 0; i < 16; i++) begin do_cmd('h30 + i); do_rd(); idle(1); end

    req = "R8";
    do_cmd('h23); do_wr('h00); do_cmd('h23); do_wr('h70);
    do_wr('h70); do_wr('h40); idle(2);
    req = "R7";
    do_wr('h45); do_wr('hC5); do_wr('h45); idle(2);

    req = "R3"; do_cmd('hB6); do_wr('h85); do_cmd('hB7); do_rd();
    req = "R4"; idle(4); do_ack(); idle(2); do_ack(); idle(1);
    req = "R5"; do_brst(); idle(1); do_cmd('hB7); do_rd(); idle(1);
    req = "R6"; do_cmd('hB6); do_wr('h22); do_brst(); idle(2); do_ack(); idle(2);
    req = "R4"; do_cmd('hB6); do_wr('h9A); do_ack(); idle(1);

    req = "R9";
    do_cmd('h40); do_wr('hFF); do_cmd('h1F); do_wr('hFF); do_cmd('hB5); do_wr('hFF);
    do_cmd('h37); do_wr('hFF); do_cmd('hB7); do_wr('hFF);
    do_cmd('h00); do_rd(); do_cmd('hB6); do_rd(); do_cmd('h2A); do_rd(); idle(1);
    req = "R10"; do_cmd('h31); do_rd(); do_cmd('h32); idle(3); do_rd(); idle(2);

    req = "R2";
    seed = 7;
    for (int i = 0; i < 300; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      case (seed % 7)
        0: do_cmd('h20 + (seed / 7) % 16);
        1: do_cmd('h30 + (seed / 7) % 16);
        2: do_cmd(((seed / 7) % 2) ? 'hB6 : 'hB7);
        3: do_wr((seed / 11) % 256);
        4: do_rd();
        5: do_ack();
        default: if ((seed / 13) % 4 == 0) do_brst(); else idle(1);
      endcase
    end
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #50000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule